// File: doc/BRIEF.md
# Spread-Spectrum Dithered PWM Generator

This block drives the power switch of a digitally controlled buck converter. A free-running tick counter sets out switching cycles, and within each cycle a single gate pulse is produced. To spread the switching energy across a wider band, the generator can move the pulse inside the cycle, lengthen or shorten the cycle, pick one of those at random, or do both at once. In every case the on-time is worked out from the commanded duty ratio and the cycle's own length, so the average duty does not move.

A 7-bit linear feedback shift register supplies one pseudo-random value per cycle. A mode decoder turns that value, together with the selected dither mode, into a position slot and a period step. The cycle planner then turns these into the cycle length, the pulse start and the pulse end. All inputs are captured only when a new cycle begins. A one-tick strobe marks tick 0 of every cycle, and the decoded mode index is held for the whole cycle, so a monitor can follow the dither pattern.

Top module: `ssc_pwm_gen`

## Requirements
- R1: A synchronous active-high reset holds `pwm_out` and `cyc_start` low and `cyc_idx` at 0. On the first clock edge with reset low, a cycle is loaded, so `cyc_start` is high right after that edge.
- R2: `mode_sel` 0 selects plain PWM. Codes 5, 6 and 7 act the same way. The period equals `per_nom`, the pulse rises at tick 0, and the index is 0.
- R3: The random source shifts left with new bit = bit6 XOR bit5. It resets to 0x5B and advances once per cycle. The value r used for a cycle is bits [3:0] of the register as it stands when that cycle is loaded.
- R4: `mode_sel` 1 (position) sets slot k = r[1:0]. Both pulse edges move later by k*`off_step` ticks, the period stays at `per_nom`, and the index is k.
- R5: `mode_sel` 2 (period) sets p = r[2:0], with 5, 6 and 7 wrapping to 0, 1 and 2. The period change for p = 0..4 is 0, +`step_a`, -`step_a`, +`step_b`, -`step_b`. The pulse starts at tick 0 and the index is p.
- R6: `mode_sel` 3 (select) sets m = r when r<9 and r-9 otherwise. For m 0..3 the slot is k=m with no period change. For m 4..8 the period step is p=m-4 with slot 0. The index is m, and over 127 cycles all nine indices appear.
- R7: `mode_sel` 4 (fused) sets m = r when r<11 and r-11 otherwise. m 0..3 gives slot m only. m 4..7 gives period step m-3 only. m 8, 9 and 10 give slot 1 with step 1, slot 2 with step 2, and slot 3 with step 3. The index is m, and all eleven indices appear.
- R8: The on-time is floor(`duty`*P/256), where P is the period of the same cycle.
- R9: P is clamped to the range 2..4095. The pulse end is limited to min(offset+on-time, P), so the pulse never crosses the cycle boundary.
- R10: A change to any input during a cycle has no effect until the next cycle starts.
- R11: `cyc_start` is high only at tick 0 of each cycle, and `cyc_idx` changes only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 3 | Dither mode code |
| per_nom | input | 12 | Nominal period in ticks |
| duty | input | 8 | Duty ratio, fraction of 256 |
| step_a | input | 8 | Small period step |
| step_b | input | 8 | Large period step |
| off_step | input | 8 | Position slot step in ticks |
| pwm_out | output | 1 | Gate-drive pulse |
| cyc_start | output | 1 | Strobe at tick 0 of each cycle |
| cyc_idx | output | 4 | Mode index of the current cycle |

## Verification
A wrong random register or a wrong decoder entry shows up at `cyc_idx` on the very next strobe, and from then on the expected sequence drifts further each cycle. A wrong period or on-time value moves a pulse edge or a strobe within the same cycle, and every later cycle boundary shifts with it. An input captured at the wrong moment alters the cycle already in progress, which shows as an early or late strobe in the tick-by-tick comparison.

// File: rtl/ssc_pwm_pkg.sv
package ssc_pwm_pkg;

    localparam int LFSR_W = 7;
    localparam int RND_W  = 4;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        SSC_PLAIN = 3'd0,
        SSC_POS   = 3'd1,
        SSC_PER   = 3'd2,
        SSC_SEL   = 3'd3,
        SSC_FUSE  = 3'd4
    } ssc_mode_e;

    typedef enum logic [2:0] {
        PD_ZERO = 3'd0,
        PD_UP1  = 3'd1,
        PD_DN1  = 3'd2,
        PD_UP2  = 3'd3,
        PD_DN2  = 3'd4
    } per_step_e;

    typedef struct packed {
        logic [1:0]       slot;
        per_step_e        pstep;
        logic [IDX_W-1:0] idx;
    } cyc_plan_t;

    // Fold a value into 0..n-1 (valid for r < 2n)
    function automatic logic [RND_W-1:0] wrap_idx(input logic [RND_W-1:0] r,
                                                  input logic [RND_W-1:0] n);
        return (r >= n) ? (r - n) : r;
    endfunction

endpackage

// File: rtl/ssc_lfsr.sv
module ssc_lfsr
    import ssc_pwm_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 7'h5B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (adv)
            state <= {state[LFSR_W-2:0], state[LFSR_W-1] ^ state[LFSR_W-2]};
    end
endmodule

// File: rtl/ssc_mode_dec.sv
module ssc_mode_dec
    import ssc_pwm_pkg::*;
(
    input  logic [2:0]       mode_sel,
    input  logic [RND_W-1:0] rnd,
    output cyc_plan_t        plan
);
    logic [RND_W-1:0] m;

    always_comb begin
        plan = '{slot: 2'd0, pstep: PD_ZERO, idx: '0};
        m    = '0;
        case (mode_sel)
            SSC_POS: begin
                plan.slot = rnd[1:0];
                plan.idx  = {2'b00, rnd[1:0]};
            end
            SSC_PER: begin
                m          = wrap_idx({1'b0, rnd[2:0]}, 4'd5);
                plan.pstep = per_step_e'(m[2:0]);
                plan.idx   = m;
            end
            SSC_SEL: begin
                m        = wrap_idx(rnd, 4'd9);
                plan.idx = m;
                if (m < 4'd4) plan.slot  = m[1:0];
                else          plan.pstep = per_step_e'(3'(m - 4'd4));
            end
            SSC_FUSE: begin
                m        = wrap_idx(rnd, 4'd11);
                plan.idx = m;
                if (m < 4'd4) begin
                    plan.slot = m[1:0];
                end else if (m < 4'd8) begin
                    plan.pstep = per_step_e'(3'(m - 4'd3));
                end else begin
                    plan.slot  = 2'(m - 4'd7);
                    plan.pstep = per_step_e'(3'(m - 4'd7));
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ssc_cycle_timer.sv
module ssc_cycle_timer
    import ssc_pwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DUTY_W = 8,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  per_nom,
    input  logic [DUTY_W-1:0] duty,
    input  logic [STEP_W-1:0] step_a,
    input  logic [STEP_W-1:0] step_b,
    input  logic [STEP_W-1:0] off_step,
    input  cyc_plan_t         plan,
    output logic              boundary,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  per_len,
    output logic              pwm,
    output logic              strobe,
    output logic [IDX_W-1:0]  idx
);
    localparam int XW   = CNT_W + 2;
    localparam int PW   = CNT_W + DUTY_W;
    localparam logic signed [XW-1:0] PMIN = XW'(2);
    localparam logic signed [XW-1:0] PMAX = XW'((1 << CNT_W) - 1);

    logic              run_q;
    logic [CNT_W-1:0]  cnt_q, per_q, st_q, en_q;
    logic [IDX_W-1:0]  idx_q;

    logic signed [XW-1:0] sa, sb, delta, per_raw;
    logic [CNT_W-1:0]     per_new, on_t, st_new, en_new;
    logic [PW-1:0]        prod;
    logic [XW-1:0]        ofs, end_raw, per_x;

    // Cycle planner: period, on-time, pulse window
    always_comb begin
        sa = $signed({{(XW-STEP_W){1'b0}}, step_a});
        sb = $signed({{(XW-STEP_W){1'b0}}, step_b});
        case (plan.pstep)
            PD_UP1:  delta = sa;
            PD_DN1:  delta = -sa;
            PD_UP2:  delta = sb;
            PD_DN2:  delta = -sb;
            default: delta = '0;
        endcase
        per_raw = $signed({2'b00, per_nom}) + delta;
        if (per_raw < PMIN)      per_new = CNT_W'(2);
        else if (per_raw > PMAX) per_new = CNT_W'((1 << CNT_W) - 1);
        else                     per_new = per_raw[CNT_W-1:0];

        prod    = {{CNT_W{1'b0}}, duty} * {{DUTY_W{1'b0}}, per_new};
        on_t    = CNT_W'(prod >> DUTY_W);
        ofs     = {{(XW-STEP_W){1'b0}}, off_step} * {{(XW-2){1'b0}}, plan.slot};
        end_raw = ofs + {2'b00, on_t};
        per_x   = {2'b00, per_new};
        st_new  = (ofs > per_x)     ? per_new : ofs[CNT_W-1:0];
        en_new  = (end_raw > per_x) ? per_new : end_raw[CNT_W-1:0];
    end

    assign boundary = !run_q || (cnt_q == per_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            per_q <= '0;
            st_q  <= '0;
            en_q  <= '0;
            idx_q <= '0;
        end else if (boundary) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            per_q <= per_new;
            st_q  <= st_new;
            en_q  <= en_new;
            idx_q <= plan.idx;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign per_len = per_q;
    assign pwm     = run_q && (cnt_q >= st_q) && (cnt_q < en_q);
    assign strobe  = run_q && (cnt_q == '0);
    assign idx     = idx_q;
endmodule

// File: rtl/ssc_pwm_gen.sv
module ssc_pwm_gen
    import ssc_pwm_pkg::*;
#(
    parameter int                CNT_W  = 12,
    parameter int                DUTY_W = 8,
    parameter int                STEP_W = 8,
    parameter logic [LFSR_W-1:0] SEED   = 7'h5B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic [CNT_W-1:0]  per_nom,
    input  logic [DUTY_W-1:0] duty,
    input  logic [STEP_W-1:0] step_a,
    input  logic [STEP_W-1:0] step_b,
    input  logic [STEP_W-1:0] off_step,
    output logic              pwm_out,
    output logic              cyc_start,
    output logic [IDX_W-1:0]  cyc_idx
);
    logic              adv;
    logic [LFSR_W-1:0] lfsr_q;
    logic [CNT_W-1:0]  cnt_w, per_w;
    cyc_plan_t         plan;

    ssc_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .state (lfsr_q)
    );

    ssc_mode_dec u_dec (
        .mode_sel (mode_sel),
        .rnd      (lfsr_q[RND_W-1:0]),
        .plan     (plan)
    );

    ssc_cycle_timer #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .STEP_W(STEP_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .per_nom  (per_nom),
        .duty     (duty),
        .step_a   (step_a),
        .step_b   (step_b),
        .off_step (off_step),
        .plan     (plan),
        .boundary (adv),
        .cnt      (cnt_w),
        .per_len  (per_w),
        .pwm      (pwm_out),
        .strobe   (cyc_start),
        .idx      (cyc_idx)
    );
endmodule

// File: rtl/ssc_pwm_chk.sv
module ssc_pwm_chk
    import ssc_pwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_out,
    input logic              cyc_start,
    input logic [IDX_W-1:0]  cyc_idx,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per_len,
    input logic [LFSR_W-1:0] lfsr_q
);
    // R1: reset silences the outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pwm_out && !cyc_start));

    // R3: random register only moves when a new cycle is loaded
    p_lfsr_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lfsr_q) |-> cyc_start);

    // R9: minimum period of two ticks, strobes never adjacent
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !cyc_start);

    // R9: pulse stays inside the cycle
    p_no_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        pwm_out |-> (cnt < per_len));

    // R11: mode index held for the whole cycle
    p_idx_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |-> $stable(cyc_idx));
endmodule

bind ssc_pwm_gen ssc_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_out   (pwm_out),
    .cyc_start (cyc_start),
    .cyc_idx   (cyc_idx),
    .cnt       (cnt_w),
    .per_len   (per_w),
    .lfsr_q    (lfsr_q)
);

// File: tb/ssc_pwm_gen_bench.sv
module ssc_pwm_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic [11:0] per_nom = 12'd20;
    logic [7:0] duty = 8'd128;
    logic [7:0] step_a = 8'd0;
    logic [7:0] step_b = 8'd0;
    logic [7:0] off_step = 8'd0;
    logic       pwm_out, cyc_start;
    logic [3:0] cyc_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference state
    int m_run, m_cnt, m_per, m_st, m_en, m_idx, m_lfsr;
    int seen_mask;

    always #4 clk = ~clk;

    ssc_pwm_gen u_ssc_pwm_gen (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .per_nom(per_nom),
        .duty(duty), .step_a(step_a), .step_b(step_b), .off_step(off_step),
        .pwm_out(pwm_out), .cyc_start(cyc_start), .cyc_idx(cyc_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Predict state after the coming edge from the requirement tables
    task automatic model_step();
        int r, k, p, m, d, P, on, ofs;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_per = 0; m_st = 0; m_en = 0; m_idx = 0;
            m_lfsr = 'h5B;
            return;
        end
        if (m_run == 0 || m_cnt == m_per - 1) begin
            r = m_lfsr & 15; k = 0; p = 0; m = 0;
            case (mode_sel)
                3'd1: begin k = r % 4; m = k; end
                3'd2: begin p = r % 8; if (p > 4) p -= 5; m = p; end
                3'd3: begin m = (r < 9) ? r : r - 9;
                            if (m < 4) k = m; else p = m - 4; end
                3'd4: begin m = (r < 11) ? r : r - 11;
                            if (m < 4) k = m;
                            else if (m < 8) p = m - 3;
                            else begin k = m - 7; p = m - 7; end end
                default: ;
            endcase
            case (p)
                1: d = step_a;
                2: d = -int'(step_a);
                3: d = step_b;
                4: d = -int'(step_b);
                default: d = 0;
            endcase
            P = int'(per_nom) + d;
            if (P < 2) P = 2;
            if (P > 4095) P = 4095;
            on = (int'(duty) * P) / 256;
            ofs = k * int'(off_step);
            m_per = P;
            m_st = (ofs > P) ? P : ofs;
            m_en = (ofs + on > P) ? P : ofs + on;
            m_idx = m;
            m_run = 1; m_cnt = 0;
            m_lfsr = ((m_lfsr << 1) & 'h7F) | (((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1);
        end else begin
            m_cnt++;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #2;
        chk({cur_req, " pwm"}, int'(pwm_out),
            (m_run != 0 && m_cnt >= m_st && m_cnt < m_en) ? 1 : 0);
        chk("R11 strobe", int'(cyc_start), (m_run != 0 && m_cnt == 0) ? 1 : 0);
        chk({cur_req, " R3 idx"}, int'(cyc_idx), m_idx);
        if (cyc_start) seen_mask |= (1 << cyc_idx);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        int n;
        rst = 1'b1;
        run(3);
        cur_req = "R1";
        chk("R1 reset pwm", int'(pwm_out), 0);
        chk("R1 reset strobe", int'(cyc_start), 0);
        chk("R1 reset idx", int'(cyc_idx), 0);
        rst = 1'b0;
        tick();
        chk("R1 first strobe", int'(cyc_start), 1);

        cur_req = "R2 R8";
        run(120);
        per_nom = 12'd37; duty = 8'd64;
        run(150);
        mode_sel = 3'd7;
        run(120);

        cur_req = "R4 R8";
        mode_sel = 3'd1; per_nom = 12'd40; duty = 8'd77; off_step = 8'd5;
        run(600);

        cur_req = "R5 R8";
        mode_sel = 3'd2; per_nom = 12'd50; step_a = 8'd4; step_b = 8'd9;
        duty = 8'd100;
        run(800);

        cur_req = "R6";
        mode_sel = 3'd3; off_step = 8'd3;
        run(60);
        seen_mask = 0;
        run(7000);
        chk("R6 distinct idx", $countones(seen_mask), 9);

        cur_req = "R7";
        mode_sel = 3'd4; duty = 8'd180;
        run(60);
        seen_mask = 0;
        run(7000);
        chk("R7 distinct idx", $countones(seen_mask), 11);

        cur_req = "R9";
        mode_sel = 3'd1; per_nom = 12'd20; duty = 8'd200; off_step = 8'd6;
        run(400);
        mode_sel = 3'd2; per_nom = 12'd5; step_a = 8'd2; step_b = 8'd20;
        run(300);
        per_nom = 12'd4090; step_b = 8'd20; step_a = 8'd3; duty = 8'd10;
        run(20000);

        cur_req = "R10";
        mode_sel = 3'd0; per_nom = 12'd30; duty = 8'd128;
        n = 0;
        while (!cyc_start && n < 10000) begin tick(); n++; end
        run(3);
        per_nom = 12'd10; duty = 8'd32;
        n = 0;
        do begin tick(); n++; end while (!cyc_start && n < 100);
        chk("R10 cycle length kept", n, 27);
        run(60);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule